// File: doc/BRIEF.md
# Two-Region Memory Verify Sequencer

This block reads back the contents of a byte-addressed target memory and compares them, one 16-bit word at a time, with expected words held in a local buffer. It walks two regions in turn: the code region, which starts at byte address zero, and then an ID region at the fixed base 0x200000. Each byte is fetched through a request/acknowledge port. Every accepted read advances an internal 22-bit table pointer by one byte. Two consecutive bytes, low first, are joined into a word. The buffer is addressed by a single word index that runs through the code words and then carries on through the ID words.

Inside the code region the pointer advance wraps modulo the code memory size, which is a power-of-two byte count set by a parameter. Because of this wrap, the pointer can never step into the ID region. The sequencer loads the ID base directly once the last code word has matched. On the first mismatch it stops and reports the byte address of the low byte of the failing word. If every word in both regions matches, it signals success.

Top module: `memVerifySeq`

## Requirements
- R1: After reset, `busy`, `rdReq`, `done`, `pass` and `fail` are all low.
- R2: A `start` pulse while idle raises `busy` and sets the pointer to byte address 0. The first read request is issued at that address.
- R3: A read request holds `rdReq` high and `rdAddr` stable until a cycle with `rdAck` high. `rdData` is taken in that same cycle, and each acknowledged read advances the pointer by exactly one byte.
- R4: For each word, the byte at the even address is read first and the byte at the odd address second. They form `{second, first}`, which is compared with `expWord` at `bufIdx`. `bufIdx` counts from 0 over the code words and continues without a break over the ID words.
- R5: Inside the code region, pointer advance wraps modulo 2^`CODE_LOG2` bytes. With `CODE_LOG2` = 6, the read after address 0x3F goes to address 0x00.
- R6: After the last code word matches, the pointer is loaded with 0x200000 and the ID words are read from there upward.
- R7: On a mismatch, `done` and `fail` pulse high for one cycle and `pass` stays low. `failAddr` holds the byte address of the low byte of the failing word, no further reads are issued, and `busy` falls.
- R8: When all words in both regions match, `done` and `pass` pulse high for one cycle, and `rdAddr` then shows 0x200000 + 2*`idWords`.
- R9: A `start` pulse while `busy` is high has no effect on the read sequence or the outcome.
- R10: A region whose word count is zero is skipped. With `codeWords` = 0, reading begins at 0x200000. With `idWords` = 0, the run ends with a pass after the code region, and `rdAddr` shows 0x200000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a verify run (accepted only while idle) |
| codeWords | input | CNT_W | Number of 16-bit words in the code region |
| idWords | input | CNT_W | Number of 16-bit words in the ID region |
| rdReq | output | 1 | Byte read request |
| rdAddr | output | PTR_W | Table pointer, the byte address of the request |
| rdAck | input | 1 | Read acknowledge, with `rdData` valid in the same cycle |
| rdData | input | 8 | Byte returned by the target |
| bufIdx | output | CNT_W+1 | Word index into the expected-data buffer |
| expWord | input | 16 | Expected word at `bufIdx` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | With `done`: every word matched |
| fail | output | 1 | With `done`: a mismatch was found |
| failAddr | output | PTR_W | Low-byte address of the mismatching word |

## Verification
Two functions can fall in the same cycle. The comparison of the final code word can coincide with the reload of the pointer to the ID base, and the error stop must win over that reload. The bench provokes this by planting a mismatch in the last code word, and separately by letting that word match, with an ID region of zero and of nonzero length. A behavioural model holds a queue of expected byte addresses and checks every acknowledged request against it on each clock. It flags any read beyond the end of the queue, so a fail that still reloaded or read into the ID region would be caught, as would a pass that omitted the reload.

// File: rtl/mvs_pkg.sv
package mvs_pkg;

  // Strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic clear;    // start of run: pointer, index and counts reset
    logic latchLo;  // accept low byte, post-increment pointer
    logic latchHi;  // accept high byte, post-increment pointer
    logic advWord;  // word matched: advance word index and count
    logic loadId;   // jump pointer to ID base, switch region
    logic setPass;  // end of run, all words matched
    logic setFail;  // end of run, mismatch found
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REGION,
    S_RDLO,
    S_RDHI,
    S_CMP
  } state_t;

endpackage

// File: rtl/mvs_ctrl.sv
module mvs_ctrl
  import mvs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    rdAck,
  input  logic    regionEmpty,
  input  logic    inId,
  input  logic    lastWord,
  input  logic    wordMatch,
  output strobe_t strb,
  output logic    rdReq,
  output logic    busy
);

  state_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strb.clear = 1'b1;
          stateNxt   = S_REGION;
        end
      end
      S_REGION: begin
        if (!regionEmpty) begin
          stateNxt = S_RDLO;
        end else if (inId) begin
          strb.setPass = 1'b1;
          stateNxt     = S_IDLE;
        end else begin
          strb.loadId = 1'b1;   // stay: re-evaluate the ID region next cycle
        end
      end
      S_RDLO: begin
        if (rdAck) begin
          strb.latchLo = 1'b1;
          stateNxt     = S_RDHI;
        end
      end
      S_RDHI: begin
        if (rdAck) begin
          strb.latchHi = 1'b1;
          stateNxt     = S_CMP;
        end
      end
      S_CMP: begin
        if (!wordMatch) begin
          strb.setFail = 1'b1;
          stateNxt     = S_IDLE;
        end else begin
          strb.advWord = 1'b1;
          if (!lastWord) begin
            stateNxt = S_RDLO;
          end else if (inId) begin
            strb.setPass = 1'b1;
            stateNxt     = S_IDLE;
          end else begin
            strb.loadId = 1'b1;
            stateNxt    = S_REGION;
          end
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign rdReq = (state == S_RDLO) || (state == S_RDHI);
  assign busy  = (state != S_IDLE);

endmodule

// File: rtl/mvs_datapath.sv
module mvs_datapath
  import mvs_pkg::*;
#(
  parameter int PTR_W     = 22,
  parameter int CODE_LOG2 = 13,
  parameter int CNT_W     = 16,
  parameter logic [PTR_W-1:0] ID_BASE = 22'h200000
)(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] codeWords,
  input  logic [CNT_W-1:0] idWords,
  input  logic [7:0]       rdData,
  input  logic [15:0]      expWord,
  output logic [PTR_W-1:0] rdAddr,
  output logic [CNT_W:0]   bufIdx,
  output logic             regionEmpty,
  output logic             inId,
  output logic             lastWord,
  output logic             wordMatch,
  output logic             done,
  output logic             pass,
  output logic             fail,
  output logic [PTR_W-1:0] failAddr
);

  localparam int HI_W = PTR_W - CODE_LOG2;

  logic [PTR_W-1:0] ptr, ptrInc, loAddr;
  logic [CNT_W:0]   idx;
  logic [CNT_W-1:0] wordCnt, codeN, idN, regionN;
  logic [7:0]       loByte, hiByte;

  // Post-increment: wraps inside the code space, linear in the ID region
  always_comb begin
    if (inId) ptrInc = ptr + 1'b1;
    else      ptrInc = {ptr[PTR_W-1 -: HI_W], ptr[CODE_LOG2-1:0] + 1'b1};
  end

  assign regionN     = inId ? idN : codeN;
  assign regionEmpty = (regionN == '0);
  assign lastWord    = (CNT_W'(wordCnt + 1'b1) == regionN);
  assign wordMatch   = ({hiByte, loByte} == expWord);
  assign rdAddr      = ptr;
  assign bufIdx      = idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      loAddr   <= '0;
      idx      <= '0;
      wordCnt  <= '0;
      codeN    <= '0;
      idN      <= '0;
      inId     <= 1'b0;
      loByte   <= '0;
      hiByte   <= '0;
      done     <= 1'b0;
      pass     <= 1'b0;
      fail     <= 1'b0;
      failAddr <= '0;
    end else begin
      done <= strb.setPass | strb.setFail;
      pass <= strb.setPass;
      fail <= strb.setFail;
      if (strb.clear) begin
        ptr     <= '0;
        idx     <= '0;
        wordCnt <= '0;
        inId    <= 1'b0;
        codeN   <= codeWords;
        idN     <= idWords;
      end
      if (strb.latchLo) begin
        loByte <= rdData;
        loAddr <= ptr;
        ptr    <= ptrInc;
      end
      if (strb.latchHi) begin
        hiByte <= rdData;
        ptr    <= ptrInc;
      end
      if (strb.advWord) begin
        idx     <= idx + 1'b1;
        wordCnt <= wordCnt + 1'b1;
      end
      if (strb.loadId) begin
        ptr     <= ID_BASE;
        inId    <= 1'b1;
        wordCnt <= '0;
      end
      if (strb.setFail) failAddr <= loAddr;
    end
  end

endmodule

// File: rtl/memVerifySeq.sv
module memVerifySeq
  import mvs_pkg::*;
#(
  parameter int PTR_W     = 22,
  parameter int CODE_LOG2 = 13,
  parameter int CNT_W     = 16,
  parameter logic [PTR_W-1:0] ID_BASE = 22'h200000
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] codeWords,
  input  logic [CNT_W-1:0] idWords,
  output logic             rdReq,
  output logic [PTR_W-1:0] rdAddr,
  input  logic             rdAck,
  input  logic [7:0]       rdData,
  output logic [CNT_W:0]   bufIdx,
  input  logic [15:0]      expWord,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             fail,
  output logic [PTR_W-1:0] failAddr
);

  strobe_t strb;
  logic regionEmpty, inId, lastWord, wordMatch;

  mvs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdAck(rdAck),
    .regionEmpty(regionEmpty), .inId(inId), .lastWord(lastWord),
    .wordMatch(wordMatch), .strb(strb), .rdReq(rdReq), .busy(busy)
  );

  mvs_datapath #(
    .PTR_W(PTR_W), .CODE_LOG2(CODE_LOG2), .CNT_W(CNT_W), .ID_BASE(ID_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .codeWords(codeWords),
    .idWords(idWords), .rdData(rdData), .expWord(expWord),
    .rdAddr(rdAddr), .bufIdx(bufIdx), .regionEmpty(regionEmpty),
    .inId(inId), .lastWord(lastWord), .wordMatch(wordMatch),
    .done(done), .pass(pass), .fail(fail), .failAddr(failAddr)
  );

endmodule

// File: rtl/memVerifySeq_chk.sv
module memVerifySeq_chk #(
  parameter int PTR_W = 22
)(
  input logic             clk,
  input logic             rstN,
  input logic             rdReq,
  input logic             rdAck,
  input logic [PTR_W-1:0] rdAddr,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic             fail
);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr)));

  // R3
  req_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> busy);

  // R2
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (rdAddr == '0));

  // R7
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pass && fail));

  // R7
  fail_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> done);

  // R8
  pass_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  run_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

bind memVerifySeq memVerifySeq_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAck(rdAck), .rdAddr(rdAddr),
  .busy(busy), .done(done), .pass(pass), .fail(fail)
);

// File: tb/tb_memVerifySeq.sv
module tb_memVerifySeq;

  localparam int PTR_W     = 22;
  localparam int CODE_LOG2 = 6;
  localparam int CNT_W     = 8;
  localparam int ID_BASE   = 32'h200000;
  localparam int CODE_MASK = (1 << CODE_LOG2) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] codeWords = '0, idWords = '0;
  logic             rdReq, rdAck = 1'b0;
  logic [PTR_W-1:0] rdAddr, failAddr;
  logic [7:0]       rdData = '0;
  logic [CNT_W:0]   bufIdx;
  logic [15:0]      expWord;
  logic             busy, done, pass, fail;

  logic [15:0] expBuf [0:(1<<(CNT_W+1))-1];

  always #5 clk = ~clk;

  memVerifySeq #(.PTR_W(PTR_W), .CODE_LOG2(CODE_LOG2), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .codeWords(codeWords),
    .idWords(idWords), .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck),
    .rdData(rdData), .bufIdx(bufIdx), .expWord(expWord), .busy(busy),
    .done(done), .pass(pass), .fail(fail), .failAddr(failAddr)
  );

  assign expWord = expBuf[bufIdx];

  int checks = 0, errors = 0, cycles = 0;
  int addrQ[$];
  bit expectPass;
  int expFailAddr, expEndAddr, doneCount, waitCnt, lat, lcg = 7;
  bit active = 0;

  function automatic logic [7:0] byteAt(int a);
    return 8'(a ^ (a >> 7) ^ 8'hA5);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Behavioural reference: queue of addresses, checked at every clock
  always @(negedge clk) begin
    cycles++;
    if (active && done) begin
      doneCount++;
      check(doneCount == 1, "R8 single done pulse", doneCount, 1);
      check(addrQ.size() == 0, "R7/R6 all expected reads made", addrQ.size(), 0);
      check(pass == expectPass, "R8 pass flag", pass, expectPass);
      check(fail == !expectPass, "R7 fail flag", fail, !expectPass);
      if (expectPass)
        check(rdAddr == PTR_W'(expEndAddr), "R8 final pointer", rdAddr, expEndAddr);
      else
        check(failAddr == PTR_W'(expFailAddr), "R7 failAddr", failAddr, expFailAddr);
    end
    if (rdAck) begin
      rdAck = 1'b0;
    end else if (rdReq) begin
      if (waitCnt >= lat) begin
        // R3 R4 R5 R6: accepted read must match the next expected address
        if (addrQ.size() == 0) begin
          check(0, "R7 no read beyond expected sequence", rdAddr, 0);
        end else begin
          check(rdAddr == PTR_W'(addrQ[0]), "R4/R5/R6 read address", rdAddr, addrQ[0]);
          void'(addrQ.pop_front());
        end
        rdData  = byteAt(int'(rdAddr));
        rdAck   = 1'b1;
        waitCnt = 0;
        lcg     = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        lat     = (lcg >> 8) % 3;
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic runTest(int codeN, int idN, int badWord, bit restart);
    int lo;
    addrQ.delete();
    expectPass = (badWord < 0);
    for (int w = 0; w < codeN; w++) begin
      lo = (2*w) & CODE_MASK;
      expBuf[w] = {byteAt((2*w+1) & CODE_MASK), byteAt(lo)};
      if (badWord < 0 || w <= badWord) begin
        addrQ.push_back(lo);
        addrQ.push_back((2*w+1) & CODE_MASK);
      end
      if (w == badWord) expFailAddr = lo;
    end
    for (int j = 0; j < idN; j++) begin
      lo = ID_BASE + 2*j;
      expBuf[codeN+j] = {byteAt(lo+1), byteAt(lo)};
      if (badWord < 0 || codeN + j <= badWord) begin
        addrQ.push_back(lo);
        addrQ.push_back(lo+1);
      end
      if (codeN + j == badWord) expFailAddr = lo;
    end
    if (badWord >= 0)
      expBuf[badWord] ^= (badWord % 2 == 1) ? 16'h8000 : 16'h0001;
    expEndAddr = ID_BASE + 2*idN;
    doneCount  = 0;
    waitCnt    = 0;
    lat        = 0;
    @(negedge clk);
    codeWords = CNT_W'(codeN);
    idWords   = CNT_W'(idN);
    start     = 1'b1;
    active    = 1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    if (restart) begin
      repeat (9) @(negedge clk);
      codeWords = '0;        // R9: start while busy must not restart
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 3000 && doneCount == 0; t++) @(negedge clk);
    repeat (6) @(negedge clk);
    check(doneCount == 1, "R7/R8/R9 run ended exactly once", doneCount, 1);
    check(busy == 1'b0, "R7/R8 busy low after end", busy, 0);
    active = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(rdReq == 0, "R1 rdReq", rdReq, 0);
    check(done == 0, "R1 done", done, 0);
    check(pass == 0, "R1 pass", pass, 0);
    check(fail == 0, "R1 fail", fail, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runTest(4, 2, -1, 0);    // R2 R4 R6 R8 basic pass
    runTest(34, 3, -1, 0);   // R5 wrap past end of code space
    runTest(6, 2, 2, 0);     // R7 mismatch in code word
    runTest(5, 3, 4, 0);     // R7 R6 mismatch on last code word: no reload
    runTest(5, 0, -1, 0);    // R10 last code word match, empty ID region
    runTest(3, 4, 4, 0);     // R4 R7 mismatch in ID word, index continuity
    runTest(0, 2, -1, 0);    // R10 empty code region
    runTest(6, 2, -1, 1);    // R9 start while busy ignored
    runTest(2, 2, 3, 0);     // R7 mismatch on last ID word
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule